// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block puts one 16-bit two's-complement sample on a self-clocked serial link for every 64-cycle slot of the master clock. The link has three lines, each with an inverted twin: a gated serial clock, an active-low frame sync and a data line. The serial clock runs at one third of the master clock. It is high for one master cycle and low for the next two. The receiver captures each data bit on the rising edge of that clock. Outside a frame the serial clock and the data line rest low and the frame sync rests high.

An upstream stage hands over a sample with a one-cycle strobe at any time. The block holds the sample until the next slot boundary and then sends it in the first 48 master cycles of that slot. If a strobe arrives while a frame is being sent, the sending frame is not touched: the new sample waits for the next slot.

A bypass input turns the link into a raw bitstream port. The modulator bit is registered and driven in return-to-zero form: during the low half of the master clock the data line carries the bit, and during the high half it reads zero. No frame and no serial clock are produced in bypass.

Top module: `framed_word_tx`

## Requirements
- R1: Inside a frame the serial clock is high for exactly one master cycle out of every three, and a frame holds exactly 16 serial-clock high cycles.
- R2: Frame sync goes low at the start of a frame and stays low for exactly 48 master cycles (16 serial-clock periods).
- R3: Numbering the master cycles of a frame from 0, the first serial-clock high cycle is cycle 2. Frame sync returns high in the cycle right after the last serial-clock high cycle, which is cycle 48.
- R4: Data goes out MSB first, unchanged from the two's-complement input word. Bit k (counted from the MSB) is driven from cycle 3k through serial-clock high cycle 3k+2, so it changes only after a serial-clock falling edge.
- R5: While reset is held and whenever no frame is running, the serial clock is low, the data line is low and frame sync is high.
- R6: A slot lasts 64 master cycles and frames begin only on slot boundaries. After reset is released, the first frame begins in the cycle that follows the 64th rising edge of the master clock. Words sent back to back begin frames exactly 64 cycles apart.
- R7: A strobe that arrives during a frame does not change the frame being sent, and its word goes out in the next slot. If two strobes arrive before one slot boundary, the later word is sent.
- R8: With bypass high, frame sync stays high and the serial clock stays low. The data line shows the modulator bit registered at the last rising edge while the master clock is low, and shows zero while it is high. Word strobes received in bypass are discarded and never produce a frame.
- R9: Each complementary output equals the bitwise inverse of its true output at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | 1 selects the return-to-zero bitstream output |
| mod_bit | input | 1 | Modulator bit, one per master cycle |
| word_valid | input | 1 | One-cycle strobe marking word_data as a new sample |
| word_data | input | 16 | Two's-complement sample |
| sclk | output | 1 | Gated serial clock |
| sclk_b | output | 1 | Inverse of sclk |
| fsync_n | output | 1 | Active-low frame sync |
| fsync_b | output | 1 | Inverse of fsync_n |
| sdata | output | 1 | Serial data or return-to-zero bitstream |
| sdata_b | output | 1 | Inverse of sdata |

## Verification
The bench walks the frame cycle by cycle with sign-boundary and alternating words. A serializer whose clock phase is off by one shifts every bit, and one that counts bits wrongly ends the frame early or late. It strobes a word halfway through a frame and checks both the running word and the 64-cycle start of the next one: a design that loads the shifter straight from a strobe corrupts the running frame. It also sends two strobes inside one slot, where a design that keeps the first word sends the stale value. In bypass it samples both halves of the master clock, which catches a non-return-to-zero output. It then checks that a word strobed during bypass never appears as a frame once bypass drops.

// File: rtl/fwt_pkg.sv
// Package: shared defaults and the serializer state type for the framed
// word transmitter. Assumes nothing beyond standard elaboration.
package fwt_pkg;
    localparam int unsigned WORD_W_DEF   = 16;
    localparam int unsigned SLOT_LEN_DEF = 64;
    localparam int unsigned SCLK_DIV_DEF = 3;

    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;
endpackage

// File: rtl/fwt_slot_timer.sv
// Free-running slot counter. Flags the last master cycle of each slot so a
// frame can begin on the next edge. Assumes SLOT_LEN >= 2.
module fwt_slot_timer #(
    parameter int unsigned SLOT_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_last
);
    localparam int unsigned CW = $clog2(SLOT_LEN);
    localparam logic [CW-1:0] LAST = CW'(SLOT_LEN - 1);

    logic [CW-1:0] cnt_q;

    // Count master cycles, wrapping at the slot length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot_last = (cnt_q == LAST);
endmodule

// File: rtl/fwt_word_holder.sv
// Holds the most recent strobed word until a slot boundary hands it to the
// serializer. Assumes strobes are one cycle wide; a later strobe replaces an
// unsent word. Bypass drops any pending word and ignores new strobes.
module fwt_word_holder #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              slot_last,
    output logic              start,
    output logic [WORD_W-1:0] held
);
    logic              pending_q;
    logic [WORD_W-1:0] hold_q;

    assign start = slot_last && pending_q && !bypass;
    assign held  = hold_q;

    // Track whether an unsent word is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (bypass) begin
            pending_q <= 1'b0;
        end else if (word_valid) begin
            pending_q <= 1'b1;
        end else if (start) begin
            pending_q <= 1'b0;
        end
    end

    // Capture the word carried by each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!bypass && word_valid) begin
            hold_q <= word_data;
        end
    end
endmodule

// File: rtl/fwt_serializer.sv
// Shifts one word out MSB first. Each bit lasts SCLK_DIV master cycles and
// the serial clock is high only in the last of them, so the receiver samples
// on the rising edge and the next bit appears after the falling edge.
// Assumes start comes only while idle; abort returns it to idle at once.
module fwt_serializer #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned SCLK_DIV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [WORD_W-1:0] load_word,
    output logic              frame_n,
    output logic              ser_clk,
    output logic              ser_data
);
    import fwt_pkg::*;

    localparam int unsigned SW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
    localparam int unsigned BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(SCLK_DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

    ser_state_e        state_q;
    logic [SW-1:0]     sub_q;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] shreg_q;

    // Frame state: enter on start, leave after the last bit or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= SER_IDLE;
        end else if (state_q == SER_IDLE) begin
            if (start) state_q <= SER_SHIFT;
        end else if (sub_q == SUB_LAST && bit_q == BIT_LAST) begin
            state_q <= SER_IDLE;
        end
    end

    // Phase within a bit and index of the bit being sent.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == SER_IDLE) begin
            sub_q <= '0;
            bit_q <= '0;
        end else if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            bit_q <= bit_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // Shift register: load at frame start, advance after each clock high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (state_q == SER_IDLE && start) begin
            shreg_q <= load_word;
        end else if (state_q == SER_SHIFT && sub_q == SUB_LAST) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
    end

    assign frame_n  = (state_q != SER_SHIFT);
    assign ser_clk  = (state_q == SER_SHIFT) && (sub_q == SUB_LAST);
    assign ser_data = (state_q == SER_SHIFT) && shreg_q[WORD_W-1];
endmodule

// File: rtl/framed_word_tx.sv
// Top of the framed word transmitter: slot timer, word holder, serializer
// and the bypass path carrying the modulator bit in return-to-zero form.
// Assumes a single master clock; the return-to-zero output is gated by the
// clock level, so it is valid only while the clock is low.
module framed_word_tx #(
    parameter int unsigned WORD_W   = fwt_pkg::WORD_W_DEF,
    parameter int unsigned SLOT_LEN = fwt_pkg::SLOT_LEN_DEF,
    parameter int unsigned SCLK_DIV = fwt_pkg::SCLK_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              mod_bit,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              sclk,
    output logic              sclk_b,
    output logic              fsync_n,
    output logic              fsync_b,
    output logic              sdata,
    output logic              sdata_b
);
    localparam int unsigned FRAME_LEN = WORD_W * SCLK_DIV;

    logic              slot_last;
    logic              start;
    logic [WORD_W-1:0] held;
    logic              ser_frame_n;
    logic              ser_clk;
    logic              ser_data;
    logic              mod_q;
    logic              rtz_bit;

    fwt_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_last (slot_last)
    );

    fwt_word_holder #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .word_valid (word_valid),
        .word_data  (word_data),
        .slot_last  (slot_last),
        .start      (start),
        .held       (held)
    );

    fwt_serializer #(.WORD_W(WORD_W), .SCLK_DIV(SCLK_DIV)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (bypass),
        .start     (start),
        .load_word (held),
        .frame_n   (ser_frame_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data)
    );

    // Register the modulator bit once per master cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mod_q <= 1'b0;
        else        mod_q <= mod_bit;
    end

    assign rtz_bit = mod_q & ~clk;

    assign sclk    = ser_clk;
    assign fsync_n = ser_frame_n;
    assign sdata   = bypass ? rtz_bit : ser_data;
    assign sclk_b  = ~sclk;
    assign fsync_b = ~fsync_n;
    assign sdata_b = ~sdata;

    if (FRAME_LEN > SLOT_LEN) begin : g_bad_cfg
        initial $error("frame does not fit in one slot");
    end
endmodule

// File: rtl/framed_word_tx_checker.sv
// Checker for the framed word transmitter: serial-clock shape, frame length,
// lead and tail timing, bit stability and the bypass idle state. The frame
// length is measured with a counter, not a long $past window.
module framed_word_tx_checker #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned SCLK_DIV = 3
) (
    input logic clk,
    input logic rst_n,
    input logic bypass,
    input logic sclk,
    input logic fsync_n,
    input logic sdata
);
    localparam int unsigned FRAME_LEN = WORD_W * SCLK_DIV;
    localparam int unsigned LW = $clog2(FRAME_LEN + 2);

    logic [LW-1:0] low_cnt;

    // Count consecutive low cycles of frame sync, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || fsync_n) low_cnt <= '0;
        else if (low_cnt != LW'(FRAME_LEN + 1)) low_cnt <= low_cnt + 1'b1;
    end

    assert_sclk_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !fsync_n);

    assert_lead_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_n) |-> !sclk);

    assert_lead_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_n) |=> !sclk);

    assert_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !$past(bypass) && $rose(fsync_n)) |-> $past(sclk));

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !$past(bypass) && $rose(fsync_n)) |-> (low_cnt == LW'(FRAME_LEN)));

    assert_bit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !bypass && !$past(bypass)) |-> $stable(sdata));

    assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (fsync_n && !sclk));
endmodule

bind framed_word_tx framed_word_tx_checker #(
    .WORD_W   (WORD_W),
    .SCLK_DIV (SCLK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bypass  (bypass),
    .sclk    (sclk),
    .fsync_n (fsync_n),
    .sdata   (sdata)
);

// File: tb/framed_word_tx_test.sv
module framed_word_tx_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass = 1'b0;
    logic        mod_bit = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        sclk, sclk_b, fsync_n, fsync_b, sdata, sdata_b;

    int total = 0;
    int fails = 0;
    int edge_n = 0;

    // Stimulus word in the upper half, expected serial word in the lower.
    localparam logic [31:0] VECS [7] = '{
        {16'h7FFF, 16'h7FFF}, {16'h8000, 16'h8000}, {16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF}, {16'hA5C3, 16'hA5C3}, {16'h0001, 16'h0001},
        {16'h5A3C, 16'h5A3C}
    };

    framed_word_tx uut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .mod_bit(mod_bit),
        .word_valid(word_valid), .word_data(word_data),
        .sclk(sclk), .sclk_b(sclk_b), .fsync_n(fsync_n), .fsync_b(fsync_b),
        .sdata(sdata), .sdata_b(sdata_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic send(input logic [15:0] w);
        word_valid = 1'b1; word_data = w;
        tick();
        word_valid = 1'b0;
    endtask

    // Wait for a frame, then sample all 48 frame cycles and the one after.
    task automatic capture(input bit mid_en, input logic [15:0] mid_w,
                           output logic [15:0] got, output bit shape_ok,
                           output bit inv_ok, output int fall_edge);
        int waited = 0;
        logic prev = 1'b0;
        got = '0; shape_ok = 1'b1; inv_ok = 1'b1;
        while (fsync_n && waited < 200) begin tick(); waited++; end
        fall_edge = edge_n;
        if (fsync_n) begin shape_ok = 1'b0; return; end
        for (int idx = 0; idx <= 48; idx++) begin
            if (idx > 0) tick();
            if (mid_en && idx == 10) begin word_valid = 1'b1; word_data = mid_w; end
            else if (mid_en && idx == 11) word_valid = 1'b0;
            if (idx < 48) begin
                if (fsync_n !== 1'b0 || sclk !== (idx % 3 == 2)) shape_ok = 1'b0;
                if (idx % 3 == 2) got = {got[14:0], sdata};
                if (idx % 3 != 0 && sdata !== prev) shape_ok = 1'b0;
            end else if (fsync_n !== 1'b1 || sclk !== 1'b0 || sdata !== 1'b0) begin
                shape_ok = 1'b0;
            end
            if (sclk_b !== ~sclk || fsync_b !== ~fsync_n || sdata_b !== ~sdata)
                inv_ok = 1'b0;
            prev = sdata;
        end
    endtask

    initial begin
        logic [15:0] got;
        bit shape_ok, inv_ok;
        int fall_a, fall_b;
        bit seen;
        bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

        // Reset state (R5, R9).
        repeat (4) tick();
        chk(fsync_n === 1'b1 && sclk === 1'b0 && sdata === 1'b0, "R5 reset idle",
            {29'd0, fsync_n, sclk, sdata}, 32'h4);
        chk(sclk_b === 1'b1 && fsync_b === 1'b0 && sdata_b === 1'b1, "R9 reset inverse",
            {29'd0, sclk_b, fsync_b, sdata_b}, 32'h5);

        // First frame after reset lands on the first slot boundary (R6).
        rst_n = 1'b1;
        send(16'h1234);
        capture(1'b0, 16'h0, got, shape_ok, inv_ok, fall_a);
        chk(fall_a == 64, "R6 first slot edge", fall_a, 64);
        chk(shape_ok, "R1 R2 R3 frame shape", shape_ok, 1);
        chk(got == 16'h1234, "R4 first word", got, 16'h1234);
        chk(inv_ok, "R9 inverse in frame", inv_ok, 1);
        tick();
        chk(sclk === 1'b0 && sdata === 1'b0 && fsync_n === 1'b1, "R5 idle after frame",
            {29'd0, fsync_n, sclk, sdata}, 32'h4);

        // Vector table walk (R1, R2, R3, R4).
        foreach (VECS[i]) begin
            send(VECS[i][31:16]);
            capture(1'b0, 16'h0, got, shape_ok, inv_ok, fall_a);
            chk(shape_ok, "R1 R2 R3 table shape", shape_ok, 1);
            chk(got == VECS[i][15:0], "R4 table word", got, VECS[i][15:0]);
        end

        // Strobe during a frame (R7) and 64-cycle spacing (R6).
        send(16'hC0DE);
        capture(1'b1, 16'h3E1F, got, shape_ok, inv_ok, fall_a);
        chk(got == 16'hC0DE && shape_ok, "R7 running frame intact", got, 16'hC0DE);
        capture(1'b0, 16'h0, got, shape_ok, inv_ok, fall_b);
        chk(got == 16'h3E1F, "R7 mid-frame word sent next", got, 16'h3E1F);
        chk(fall_b - fall_a == 64, "R6 back-to-back spacing", fall_b - fall_a, 64);

        // Two strobes in one slot: later word wins (R7).
        send(16'h1111);
        send(16'h2222);
        capture(1'b0, 16'h0, got, shape_ok, inv_ok, fall_a);
        chk(got == 16'h2222, "R7 later strobe wins", got, 16'h2222);
        chk(fall_a - fall_b == 64, "R6 next slot after replace", fall_a - fall_b, 64);

        // Bypass: return-to-zero bitstream, no frame (R8, R9).
        repeat (20) tick();
        bypass = 1'b1;
        tick();
        foreach (pat[i]) begin
            mod_bit = pat[i];
            @(posedge clk); #1;
            chk(sdata === 1'b0 && sdata_b === 1'b1, "R8 zero in high half", sdata, 0);
            @(negedge clk); #1;
            chk(sdata === pat[i] && sdata_b === ~pat[i], "R8 bit in low half",
                sdata, pat[i]);
            chk(fsync_n === 1'b1 && sclk === 1'b0, "R8 no frame in bypass",
                {30'd0, fsync_n, sclk}, 32'h2);
        end
        send(16'hBEEF);
        bypass = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 140; k++) begin
            tick();
            if (fsync_n !== 1'b1) seen = 1'b1;
        end
        chk(!seen, "R8 bypass strobe discarded", seen, 0);

        // Normal operation resumes after bypass (R4).
        send(16'h0F0F);
        capture(1'b0, 16'h0, got, shape_ok, inv_ok, fall_a);
        chk(got == 16'h0F0F && shape_ok, "R4 word after bypass", got, 16'h0F0F);

        summary();
        $finish;
    end
endmodule